// File: doc/BRIEF.md
# Network Controller Command and Status Register Unit

This block is the host-facing command and status front end of a simple network controller. A host reaches it over a byte-addressed register bus with a 32-bit data path and per-byte enables. The block shows the states of the receive unit and the command unit and latches six event bits. It lets the host clear those event bits by writing ones. It holds a general-purpose 32-bit pointer register. It drives one interrupt output, which the host can mask.

Commands are written as a byte. The upper nibble is for the command unit and the lower nibble is for the receive unit. Each nibble stays visible to the host until its unit accepts it. Each unit signals that it can take a command through a ready input. On acceptance the block pulses a take strobe, presents the command code, and, for the codes that need an address, copies the pointer register into that unit's operand output at that instant. The DMA engines and the frame processing sit outside the block. They talk to it only through the ready, take, state and event signals.

Top module: `nic_cmd_stat`

## Requirements
- R1: After reset, control word 0 reads 0x0100_0000 when both state inputs are 0. This means the event bits and the command byte are zero, and the interrupt mask (byte 3, bit 0) is 1. The pointer word reads 0, `irq` is 0 and both take strobes are 0.
- R2: Status bits 5:0 show `ru_state_i`: code 0 gives 0x00 (idle), 1 gives 0x04 (suspended), 2 gives 0x08 (no resources) and 3 gives 0x10 (ready). Status bits 7:6 show `cu_state_i` unchanged: 00 is idle, 01 is suspended and 10 is active.
- R3: An event input that is high at a clock edge sets its status bit from that edge on: `evt_cmd_done` sets bit 15, `evt_frame_rx` bit 14, `evt_rx_not_ready` bit 12 and `evt_mgmt_done` bit 11. Bit 13 is set at the edge where `cu_state_i` stops being 10. A set bit stays set until the host acknowledges it.
- R4: A write to word 0 with byte enable 1 clears each status bit 8+k whose data bit 8+k is 1. Bits written as 0 keep their value. A write to byte 0 (the state byte) has no effect.
- R5: If an event input and a host acknowledge hit the same bit in the same cycle, the bit ends up set.
- R6: A write to byte 3 stores data bit 24 as the interrupt mask. A 1 in data bit 25 sets status bit 10 (software event). Byte 3 reads back as the mask in bit 0, with zeros elsewhere.
- R7: `irq` is 1 exactly when at least one of status bits 15:10 is set and the mask is 0.
- R8: A write to byte 2 (data bits 23:16) loads the pending command. The upper nibble goes to the command unit and the lower nibble to the receive unit. A nonzero nibble reads back unchanged while its unit's ready input is low. One edge after the ready input is sampled high, the nibble reads 0, and the take strobe is high for exactly one cycle with the nibble value on the code output.
- R9: The two nibbles are accepted and cleared independently. The command byte reads 0 only when both have been accepted.
- R10: Command-unit codes 1, 4 and 6 and receive-unit codes 1, 5 and 6 copy the pointer register into that unit's operand output. The value copied is the one the register holds at the acceptance edge.
- R11: All other accepted codes leave that unit's operand output unchanged.
- R12: Word 1 is the pointer register. Each byte lane is written only when its byte enable is 1, and the register reads back its stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_en | input | 1 | Host access strobe |
| host_we | input | 1 | Host access is a write |
| host_word_sel | input | 1 | 0 selects the control word, 1 selects the pointer word |
| host_be | input | 4 | Byte enables for a write |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data of the selected word |
| ru_state_i | input | 2 | Receive-unit state code |
| cu_state_i | input | 2 | Command-unit state code |
| evt_cmd_done | input | 1 | Command executed event |
| evt_frame_rx | input | 1 | Frame received event |
| evt_rx_not_ready | input | 1 | Receiver not ready event |
| evt_mgmt_done | input | 1 | Management access done event |
| cu_ready | input | 1 | Command unit can take a command |
| cu_take | output | 1 | Command-unit acceptance strobe |
| cu_code | output | 4 | Accepted command-unit code |
| cu_operand | output | 32 | Command-unit operand |
| ru_ready | input | 1 | Receive unit can take a command |
| ru_take | output | 1 | Receive-unit acceptance strobe |
| ru_code | output | 4 | Accepted receive-unit code |
| ru_operand | output | 32 | Receive-unit operand |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the following properties on every cycle. A masked interrupt stays low. Event inputs set their bits, and a set bit beats a simultaneous acknowledge. A pending nibble with its ready input high is accepted with a take strobe on the next edge. A take never appears without a pending command, and a pending nibble holds while its ready input is low. Operands move only on a take.

Other behaviour can only be shown by the bench's scenarios. These include the state-field encodings and the derived command-unit-left-active event. They also include the read-only state byte, the pointer value being sampled at acceptance rather than at command write, the codes that take no operand, and byte-enable merging into the pointer. A random phase compares the event bits and `irq` against a bench model under mixed events, acknowledges and mask writes.

// File: rtl/nic_cs_pkg.sv
package nic_cs_pkg;

  localparam int EVT_W   = 6;
  localparam int EVT_LSB = 10;
  localparam int NIB_W   = 4;

  // event slot positions inside the event vector (status bit = EVT_LSB + slot)
  localparam int EV_SWI  = 0;
  localparam int EV_MGMT = 1;
  localparam int EV_RNR  = 2;
  localparam int EV_CNA  = 3;
  localparam int EV_FR   = 4;
  localparam int EV_CX   = 5;

  // byte lanes of the control word
  localparam int LANE_STAT = 0;
  localparam int LANE_ACK  = 1;
  localparam int LANE_CMD  = 2;
  localparam int LANE_ICTL = 3;

  typedef enum logic [1:0] {
    CU_IDLE   = 2'b00,
    CU_SUSP   = 2'b01,
    CU_ACTIVE = 2'b10,
    CU_RSVD   = 2'b11
  } cu_state_e;

  typedef logic [NIB_W-1:0] cmd_nib_t;

  // receive-unit state code to status field
  function automatic logic [5:0] ru_field(input logic [1:0] code);
    logic [5:0] f;
    case (code)
      2'd1:    f = 6'h04;
      2'd2:    f = 6'h08;
      2'd3:    f = 6'h10;
      default: f = 6'h00;
    endcase
    return f;
  endfunction

  // codes that carry the pointer register as operand
  function automatic logic uses_ptr(input logic is_cu, input cmd_nib_t c);
    logic r;
    if (is_cu) r = (c == 4'h1) || (c == 4'h4) || (c == 4'h6);
    else       r = (c == 4'h1) || (c == 4'h5) || (c == 4'h6);
    return r;
  endfunction

endpackage

// File: rtl/nic_cs_host.sv
module nic_cs_host
  import nic_cs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PTR_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_en,
  input  logic              host_we,
  input  logic              host_word_sel,
  input  logic [DATA_W/8-1:0] host_be,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic [EVT_W-1:0]  ev_bits,
  input  logic [7:0]        cmd_pend,
  input  logic [7:0]        stat_low,
  output logic              ack_en,
  output logic [EVT_W-1:0]  ack_bits,
  output logic              cmd_en,
  output logic [7:0]        cmd_byte,
  output logic              swi_set,
  output logic              mask_q,
  output logic [PTR_W-1:0]  gen_ptr
);

  localparam int NBYTES = DATA_W / 8;
  localparam int PBYTES = PTR_W / 8;

  logic             wr_ctl;
  logic             wr_ptr;
  logic             mask_d;
  logic             mask_en;
  logic [PTR_W-1:0] ptr_d;

  assign wr_ctl = host_en && host_we && !host_word_sel;
  assign wr_ptr = host_en && host_we &&  host_word_sel;

  // write strobes toward the event and command logic
  assign ack_en   = wr_ctl && host_be[LANE_ACK];
  assign ack_bits = host_wdata[EVT_LSB +: EVT_W];
  assign cmd_en   = wr_ctl && host_be[LANE_CMD];
  assign cmd_byte = host_wdata[LANE_CMD*8 +: 8];
  assign mask_en  = wr_ctl && host_be[LANE_ICTL];
  assign swi_set  = mask_en && host_wdata[LANE_ICTL*8 + 1];

  // next state: interrupt mask
  always_comb begin
    mask_d = mask_q;
    if (mask_en) mask_d = host_wdata[LANE_ICTL*8];
  end

  // next state: pointer register, one lane per byte enable
  for (genvar b = 0; b < PBYTES; b++) begin : g_ptr_lane
    always_comb begin
      ptr_d[b*8 +: 8] = gen_ptr[b*8 +: 8];
      if (wr_ptr && host_be[b]) ptr_d[b*8 +: 8] = host_wdata[b*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= 1'b1;
      gen_ptr <= '0;
    end else begin
      mask_q  <= mask_d;
      gen_ptr <= ptr_d;
    end
  end

  // read mux
  logic [DATA_W-1:0] ctl_word;
  always_comb begin
    ctl_word = '0;
    ctl_word[LANE_STAT*8 +: 8]   = stat_low;
    ctl_word[EVT_LSB +: EVT_W]   = ev_bits;
    ctl_word[LANE_CMD*8 +: 8]    = cmd_pend;
    ctl_word[LANE_ICTL*8]        = mask_q;
  end

  assign host_rdata = host_word_sel ? DATA_W'(gen_ptr) : ctl_word;

  logic unused_ok;
  assign unused_ok = ^{host_be[NBYTES-1:0]};

endmodule

// File: rtl/nic_cs_events.sv
module nic_cs_events
  import nic_cs_pkg::*;
#(
  parameter int N_EV = EVT_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_EV-1:0] ev_in,
  input  logic [1:0]      cu_state,
  input  logic            ack_en,
  input  logic [N_EV-1:0] ack_bits,
  input  logic            mask,
  output logic [N_EV-1:0] ev_q,
  output logic            irq
);

  logic [1:0]      cu_prev_q;
  logic [N_EV-1:0] ev_d;
  logic [N_EV-1:0] ev_set;
  logic [N_EV-1:0] ev_clr;
  logic            cu_left;

  assign cu_left = (cu_prev_q == CU_ACTIVE) && (cu_state != CU_ACTIVE);

  always_comb begin
    ev_set         = ev_in;
    ev_set[EV_CNA] = ev_in[EV_CNA] | cu_left;
    ev_clr         = ack_en ? ack_bits : '0;
    // a new event overrides a same-cycle acknowledge
    ev_d           = ev_set | (ev_q & ~ev_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q      <= '0;
      cu_prev_q <= CU_IDLE;
    end else begin
      ev_q      <= ev_d;
      cu_prev_q <= cu_state;
    end
  end

  assign irq = (|ev_q) && !mask;

endmodule

// File: rtl/nic_cs_unit.sv
module nic_cs_unit
  import nic_cs_pkg::*;
#(
  parameter bit IS_CU = 1'b1,
  parameter int PTR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  cmd_nib_t         wr_nib,
  input  logic             ready,
  input  logic [PTR_W-1:0] gen_ptr,
  output cmd_nib_t         pend_q,
  output logic             take_q,
  output cmd_nib_t         code_q,
  output logic [PTR_W-1:0] op_q
);

  logic             accept;
  logic             op_en;
  cmd_nib_t         pend_d;
  logic             take_d;
  cmd_nib_t         code_d;
  logic [PTR_W-1:0] op_d;

  assign accept = (pend_q != '0) && ready;
  assign op_en  = accept && uses_ptr(IS_CU, pend_q);

  always_comb begin
    pend_d = pend_q;
    if (accept) pend_d = '0;
    if (wr_en)  pend_d = wr_nib;   // a host write replaces the slot
    take_d = accept;
    code_d = accept ? pend_q : code_q;
    op_d   = op_en ? gen_ptr : op_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      take_q <= 1'b0;
      code_q <= '0;
      op_q   <= '0;
    end else begin
      pend_q <= pend_d;
      take_q <= take_d;
      code_q <= code_d;
      op_q   <= op_d;
    end
  end

endmodule

// File: rtl/nic_cmd_stat.sv
module nic_cmd_stat
  import nic_cs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PTR_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_en,
  input  logic              host_we,
  input  logic              host_word_sel,
  input  logic [DATA_W/8-1:0] host_be,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic [1:0]        ru_state_i,
  input  logic [1:0]        cu_state_i,
  input  logic              evt_cmd_done,
  input  logic              evt_frame_rx,
  input  logic              evt_rx_not_ready,
  input  logic              evt_mgmt_done,
  input  logic              cu_ready,
  output logic              cu_take,
  output logic [NIB_W-1:0]  cu_code,
  output logic [PTR_W-1:0]  cu_operand,
  input  logic              ru_ready,
  output logic              ru_take,
  output logic [NIB_W-1:0]  ru_code,
  output logic [PTR_W-1:0]  ru_operand,
  output logic              irq
);

  localparam int N_UNIT = 2;   // slot 0: command unit, slot 1: receive unit

  logic             ack_en;
  logic [EVT_W-1:0] ack_bits;
  logic             cmd_en;
  logic [7:0]       cmd_byte;
  logic             swi_set;
  logic             mask_q;
  logic [PTR_W-1:0] gen_ptr;
  logic [EVT_W-1:0] ev_bits;
  logic [EVT_W-1:0] ev_raw;
  logic [7:0]       stat_low;
  logic [7:0]       cmd_pend;
  cmd_nib_t         cu_pend;
  cmd_nib_t         ru_pend;

  logic             u_ready [N_UNIT];
  cmd_nib_t         u_pend  [N_UNIT];
  logic             u_take  [N_UNIT];
  cmd_nib_t         u_code  [N_UNIT];
  logic [PTR_W-1:0] u_op    [N_UNIT];

  assign stat_low = {cu_state_i, ru_field(ru_state_i)};

  always_comb begin
    ev_raw          = '0;
    ev_raw[EV_SWI]  = swi_set;
    ev_raw[EV_MGMT] = evt_mgmt_done;
    ev_raw[EV_RNR]  = evt_rx_not_ready;
    ev_raw[EV_FR]   = evt_frame_rx;
    ev_raw[EV_CX]   = evt_cmd_done;
  end

  nic_cs_host #(
    .DATA_W (DATA_W),
    .PTR_W  (PTR_W)
  ) u_host (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_en       (host_en),
    .host_we       (host_we),
    .host_word_sel (host_word_sel),
    .host_be       (host_be),
    .host_wdata    (host_wdata),
    .host_rdata    (host_rdata),
    .ev_bits       (ev_bits),
    .cmd_pend      (cmd_pend),
    .stat_low      (stat_low),
    .ack_en        (ack_en),
    .ack_bits      (ack_bits),
    .cmd_en        (cmd_en),
    .cmd_byte      (cmd_byte),
    .swi_set       (swi_set),
    .mask_q        (mask_q),
    .gen_ptr       (gen_ptr)
  );

  nic_cs_events #(
    .N_EV (EVT_W)
  ) u_events (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_in    (ev_raw),
    .cu_state (cu_state_i),
    .ack_en   (ack_en),
    .ack_bits (ack_bits),
    .mask     (mask_q),
    .ev_q     (ev_bits),
    .irq      (irq)
  );

  assign u_ready[0] = cu_ready;
  assign u_ready[1] = ru_ready;

  for (genvar u = 0; u < N_UNIT; u++) begin : g_unit
    nic_cs_unit #(
      .IS_CU (u == 0),
      .PTR_W (PTR_W)
    ) u_unit (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cmd_en),
      .wr_nib  (cmd_byte[(N_UNIT-1-u)*NIB_W +: NIB_W]),
      .ready   (u_ready[u]),
      .gen_ptr (gen_ptr),
      .pend_q  (u_pend[u]),
      .take_q  (u_take[u]),
      .code_q  (u_code[u]),
      .op_q    (u_op[u])
    );
  end

  assign cu_pend    = u_pend[0];
  assign ru_pend    = u_pend[1];
  assign cmd_pend   = {cu_pend, ru_pend};
  assign cu_take    = u_take[0];
  assign cu_code    = u_code[0];
  assign cu_operand = u_op[0];
  assign ru_take    = u_take[1];
  assign ru_code    = u_code[1];
  assign ru_operand = u_op[1];

endmodule

// File: rtl/nic_cmd_stat_chk.sv
module nic_cmd_stat_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        irq,
  input logic        mask_q,
  input logic [5:0]  ev_bits,
  input logic        evt_frame_rx,
  input logic        evt_cmd_done,
  input logic        ack_en,
  input logic [5:0]  ack_bits,
  input logic        cmd_en,
  input logic [3:0]  cu_pend,
  input logic [3:0]  ru_pend,
  input logic        cu_ready,
  input logic        ru_ready,
  input logic        cu_take,
  input logic        ru_take,
  input logic [31:0] cu_operand,
  input logic [31:0] ru_operand
);

  assert_mask_blocks_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q |-> !irq);

  assert_frame_sets_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_frame_rx |=> ev_bits[4]);

  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_en && ack_bits[5] && !evt_cmd_done) |=> !ev_bits[5]);

  assert_event_beats_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_cmd_done |=> ev_bits[5]);

  assert_cu_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cu_pend != 4'h0 && cu_ready && !cmd_en) |=> (cu_take && cu_pend == 4'h0));

  assert_take_needs_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cu_take |-> $past(cu_pend != 4'h0));

  assert_ru_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ru_pend != 4'h0 && !ru_ready && !cmd_en) |=> $stable(ru_pend));

  assert_cu_operand_still_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cu_take |-> $stable(cu_operand));

  assert_ru_operand_still_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ru_take |-> $stable(ru_operand));

endmodule

bind nic_cmd_stat nic_cmd_stat_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .irq          (irq),
  .mask_q       (mask_q),
  .ev_bits      (ev_bits),
  .evt_frame_rx (evt_frame_rx),
  .evt_cmd_done (evt_cmd_done),
  .ack_en       (ack_en),
  .ack_bits     (ack_bits),
  .cmd_en       (cmd_en),
  .cu_pend      (cu_pend),
  .ru_pend      (ru_pend),
  .cu_ready     (cu_ready),
  .ru_ready     (ru_ready),
  .cu_take      (cu_take),
  .ru_take      (ru_take),
  .cu_operand   (cu_operand),
  .ru_operand   (ru_operand)
);

// File: tb/nic_cmd_stat_tb.sv
module nic_cmd_stat_tb;

  logic        clk;
  logic        rst_n;
  logic        host_en, host_we, host_word_sel;
  logic [3:0]  host_be;
  logic [31:0] host_wdata, host_rdata;
  logic [1:0]  ru_state_i, cu_state_i;
  logic        evt_cmd_done, evt_frame_rx, evt_rx_not_ready, evt_mgmt_done;
  logic        cu_ready, cu_take, ru_ready, ru_take, irq;
  logic [3:0]  cu_code, ru_code;
  logic [31:0] cu_operand, ru_operand;

  int n_chk;
  int n_fail;
  bit done;

  nic_cmd_stat u_dut (
    .clk (clk), .rst_n (rst_n),
    .host_en (host_en), .host_we (host_we), .host_word_sel (host_word_sel),
    .host_be (host_be), .host_wdata (host_wdata), .host_rdata (host_rdata),
    .ru_state_i (ru_state_i), .cu_state_i (cu_state_i),
    .evt_cmd_done (evt_cmd_done), .evt_frame_rx (evt_frame_rx),
    .evt_rx_not_ready (evt_rx_not_ready), .evt_mgmt_done (evt_mgmt_done),
    .cu_ready (cu_ready), .cu_take (cu_take), .cu_code (cu_code), .cu_operand (cu_operand),
    .ru_ready (ru_ready), .ru_take (ru_take), .ru_code (ru_code), .ru_operand (ru_operand),
    .irq (irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [5:0] exp_ru_field(input logic [1:0] c);
    case (c)
      2'd0: return 6'h00;
      2'd1: return 6'h04;
      2'd2: return 6'h08;
      default: return 6'h10;
    endcase
  endfunction

  function automatic logic [5:0] exp_ev_next(input logic [5:0] cur, input logic [5:0] set,
                                             input logic [5:0] clr);
    return set | (cur & ~clr);
  endfunction

  function automatic logic exp_irq(input logic [5:0] ev, input logic m);
    return (ev != 6'h0) && !m;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic sel, input logic [3:0] be, input logic [31:0] d);
    host_en = 1'b1; host_we = 1'b1; host_word_sel = sel; host_be = be; host_wdata = d;
    @(negedge clk);
    host_en = 1'b0; host_we = 1'b0; host_be = 4'h0; host_word_sel = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] d);
    host_word_sel = sel;
    #1;
    d = host_rdata;
    host_word_sel = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    logic [31:0] rv;
    logic [5:0]  ev_m, set_m, clr_m;
    logic        mask_m;
    void'($urandom(32'd1357));
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0;
    host_en = 0; host_we = 0; host_word_sel = 0; host_be = 0; host_wdata = 0;
    ru_state_i = 0; cu_state_i = 0;
    evt_cmd_done = 0; evt_frame_rx = 0; evt_rx_not_ready = 0; evt_mgmt_done = 0;
    cu_ready = 0; ru_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(0, rv); chk("R1 control word", rv, 32'h0100_0000);
    rd(1, rv); chk("R1 pointer word", rv, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 takes", {30'b0, cu_take, ru_take}, 32'h0);

    // R2 state fields
    for (int c = 0; c < 4; c++) begin
      ru_state_i = 2'(c);
      @(negedge clk);
      rd(0, rv); chk("R2 ru field", {24'b0, rv[7:0]}, {26'b0, exp_ru_field(2'(c))});
    end
    ru_state_i = 0;
    for (int c = 0; c < 3; c++) begin
      cu_state_i = 2'(c);
      @(negedge clk);
      rd(0, rv); chk("R2 cu field", {30'b0, rv[7:6]}, 32'(c));
    end

    // R3 events (cu leaves active first)
    cu_state_i = 2'b00;
    @(negedge clk);
    rd(0, rv); chk("R3 cu left active", {24'b0, rv[15:8]}, 32'h20);
    evt_mgmt_done = 1; @(negedge clk); evt_mgmt_done = 0;
    rd(0, rv); chk("R3 mgmt", {24'b0, rv[15:8]}, 32'h28);
    evt_rx_not_ready = 1; @(negedge clk); evt_rx_not_ready = 0;
    rd(0, rv); chk("R3 rnr", {24'b0, rv[15:8]}, 32'h38);
    evt_frame_rx = 1; @(negedge clk); evt_frame_rx = 0;
    rd(0, rv); chk("R3 frame", {24'b0, rv[15:8]}, 32'h78);
    evt_cmd_done = 1; @(negedge clk); evt_cmd_done = 0;
    rd(0, rv); chk("R3 cmd done", {24'b0, rv[15:8]}, 32'hF8);
    chk("R7 masked irq", {31'b0, irq}, 32'h0);

    // R4 acknowledge and read-only state byte
    bus_wr(0, 4'b0010, 32'h0000_5300);
    rd(0, rv); chk("R4 partial ack", {24'b0, rv[15:8]}, 32'hA8);
    bus_wr(0, 4'b0001, 32'h0000_00FF);
    rd(0, rv); chk("R4 state byte write ignored", {16'b0, rv[15:0]}, 32'hA800);
    bus_wr(0, 4'b0010, 32'h0000_FF00);
    rd(0, rv); chk("R4 full ack", {24'b0, rv[15:8]}, 32'h0);

    // R5 event beats acknowledge
    evt_cmd_done = 1;
    bus_wr(0, 4'b0010, 32'h0000_8000);
    evt_cmd_done = 0;
    rd(0, rv); chk("R5 event wins", {24'b0, rv[15:8]}, 32'h80);
    bus_wr(0, 4'b0010, 32'h0000_FF00);

    // R6 / R7 interrupt control
    bus_wr(0, 4'b1000, 32'h0200_0000);
    rd(0, rv); chk("R6 swi and mask clear", rv, 32'h0000_0400);
    chk("R7 irq unmasked", {31'b0, irq}, 32'h1);
    bus_wr(0, 4'b1000, 32'h0100_0000);
    rd(0, rv); chk("R6 mask readback", rv, 32'h0100_0400);
    chk("R7 irq masked", {31'b0, irq}, 32'h0);
    bus_wr(0, 4'b1000, 32'h0000_0000);
    chk("R7 irq unmask again", {31'b0, irq}, 32'h1);
    bus_wr(0, 4'b0010, 32'h0000_0400);
    chk("R7 irq after ack", {31'b0, irq}, 32'h0);

    // R12 pointer, R8 pending, R10 sample at acceptance
    bus_wr(1, 4'b1111, 32'h1234_5678);
    rd(1, rv); chk("R12 pointer full", rv, 32'h1234_5678);
    bus_wr(0, 4'b0100, 32'h0010_0000);
    rd(0, rv); chk("R8 pending readback", {24'b0, rv[23:16]}, 32'h10);
    repeat (3) @(negedge clk);
    rd(0, rv); chk("R8 held without ready", {24'b0, rv[23:16]}, 32'h10);
    chk("R8 no take without ready", {31'b0, cu_take}, 32'h0);
    bus_wr(1, 4'b1111, 32'hCAFE_0001);
    cu_ready = 1; @(negedge clk);
    chk("R8 cu take", {31'b0, cu_take}, 32'h1);
    chk("R8 cu code", {28'b0, cu_code}, 32'h1);
    rd(0, rv); chk("R8 cleared", {24'b0, rv[23:16]}, 32'h0);
    chk("R10 cu operand sampled", cu_operand, 32'hCAFE_0001);
    cu_ready = 0; @(negedge clk);
    chk("R8 single take", {31'b0, cu_take}, 32'h0);

    // R11 resume has no operand
    bus_wr(0, 4'b0100, 32'h0020_0000);
    bus_wr(1, 4'b1111, 32'h0BAD_F00D);
    cu_ready = 1; @(negedge clk);
    chk("R11 cu take resume", {28'b0, cu_code}, 32'h2);
    chk("R11 cu operand kept", cu_operand, 32'hCAFE_0001);
    cu_ready = 0; @(negedge clk);

    // R9 independent nibbles
    bus_wr(0, 4'b0100, 32'h0021_0000);
    rd(0, rv); chk("R9 both pending", {24'b0, rv[23:16]}, 32'h21);
    ru_ready = 1; @(negedge clk);
    rd(0, rv); chk("R9 ru cleared only", {24'b0, rv[23:16]}, 32'h20);
    chk("R9 ru take", {27'b0, ru_take, ru_code}, 32'h11);
    chk("R9 cu no take", {31'b0, cu_take}, 32'h0);
    chk("R10 ru operand", ru_operand, 32'h0BAD_F00D);
    ru_ready = 0; cu_ready = 1; @(negedge clk);
    rd(0, rv); chk("R9 both cleared", {24'b0, rv[23:16]}, 32'h0);
    chk("R9 cu take", {27'b0, cu_take, cu_code}, 32'h12);
    cu_ready = 0; @(negedge clk);

    // R12 byte enables
    bus_wr(1, 4'b0010, 32'h0000_AA00);
    rd(1, rv); chk("R12 lane merge", rv, 32'h0BAD_AA0D);

    // R11 receive abort keeps operand
    bus_wr(0, 4'b0100, 32'h0004_0000);
    ru_ready = 1; @(negedge clk);
    chk("R11 ru abort code", {28'b0, ru_code}, 32'h4);
    chk("R11 ru operand kept", ru_operand, 32'h0BAD_F00D);
    ru_ready = 0; @(negedge clk);

    // random phase: events, acknowledges and mask against the model (R3 R4 R5 R7)
    bus_wr(0, 4'b0010, 32'h0000_FF00);
    ev_m = 6'h0; mask_m = 1'b0;
    for (int i = 0; i < 400; i++) begin
      logic [1:0] op;
      logic [7:0] b;
      evt_cmd_done     = ($urandom % 4) == 0;
      evt_frame_rx     = ($urandom % 4) == 0;
      evt_rx_not_ready = ($urandom % 4) == 0;
      evt_mgmt_done    = ($urandom % 4) == 0;
      op = 2'($urandom % 4);
      b  = 8'($urandom);
      set_m = {evt_cmd_done, evt_frame_rx, 1'b0, evt_rx_not_ready, evt_mgmt_done, 1'b0};
      clr_m = 6'h0;
      if (op == 2'd2) begin
        host_en = 1; host_we = 1; host_be = 4'b0010; host_wdata = {16'h0, b, 8'h0};
        clr_m = b[7:2];
      end else if (op == 2'd3) begin
        host_en = 1; host_we = 1; host_be = 4'b1000; host_wdata = {6'b0, b[1:0], 24'h0};
        set_m[0] = b[1];
      end
      @(negedge clk);
      host_en = 0; host_we = 0; host_be = 0;
      evt_cmd_done = 0; evt_frame_rx = 0; evt_rx_not_ready = 0; evt_mgmt_done = 0;
      ev_m = exp_ev_next(ev_m, set_m, clr_m);
      if (op == 2'd3) mask_m = b[0];
      rd(0, rv);
      chk("R3 R4 R5 random events", {26'b0, rv[15:10]}, {26'b0, ev_m});
      chk("R7 random irq", {31'b0, irq}, {31'b0, exp_irq(ev_m, mask_m)});
    end

    finish_run();
  end

endmodule